// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back, write-allocate data cache. It pairs a direct-mapped main array with a small fully associative victim buffer. A CPU-side port takes one word request at a time through a valid/ready handshake. A lower-memory port moves whole blocks. Any valid block that leaves the main array is pushed into the victim buffer instead of being thrown away.

When a request misses the main array, the victim buffer is searched by full block address. On a victim hit, the victim block and the displaced main block change places in one clock edge, and the retried lookup then hits. Memory is asked for a block only when both structures miss. The victim buffer is kept in insertion order, so when it is full the oldest entry is pushed out. If that entry is dirty, it is written back to memory before the fetch starts.

By default the main array holds 256 blocks of four 32-bit words (4 KB). The victim buffer holds 4 entries. Addresses on the CPU port are word addresses.

Top module: `dmvc_cache`

## Requirements
- R1: After reset, cpu_req_ready is 1 and cpu_resp_valid and mem_req_valid are 0. Every main line and victim entry is invalid, so the first access to any block issues a memory read.
- R2: A read that hits the main array raises cpu_resp_valid in the cycle after the accepting clock edge, returns the addressed word and causes no memory request.
- R3: A write that hits replaces the word selected by address bits [1:0] (the word index within the block) and marks the line dirty. It sends nothing to memory and answers one cycle after acceptance, echoing the write data on cpu_resp_rdata. A write miss allocates the block like a read miss.
- R4: A valid block displaced from the main array is inserted into the victim buffer with its dirty state. It is neither written to memory nor dropped at that point.
- R5: A main miss that hits the victim buffer swaps the two blocks and answers two cycles after acceptance, with no memory request.
- R6: Data written into a block survives any number of moves between the main array and the victim buffer. When the block is later refetched from memory, the written data returns.
- R7: The victim buffer keeps insertion order. A swap leaves the displaced main block in the hit entry's position. When the buffer is full, an insertion drops only the oldest entry.
- R8: When the oldest victim entry is pushed out and is dirty, its whole block is written to memory at its own block address before the fetch is issued. A clean entry is dropped with no memory write.
- R9: A memory read is issued only when both the main array and the victim buffer miss. Its block address is cpu address bits [ADDR_W-1:2] (word index stripped). The returned block is stored clean, with word w in bits [w*WORD_W +: WORD_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | WORD_W | Write data |
| cpu_resp_valid | output | 1 | Response present for one cycle |
| cpu_resp_rdata | output | WORD_W | Read data, or echoed write data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = block write-back, 0 = block read |
| mem_req_baddr | output | ADDR_W-2 | Block address |
| mem_req_wdata | output | WORD_W*BLK_WORDS | Write-back block |
| mem_resp_valid | input | 1 | Read block returned |
| mem_resp_rdata | input | WORD_W*BLK_WORDS | Returned block |

## Verification
The bench builds the cache with ADDR_W=8 and SETS=4 and keeps 4-word blocks and a 4-entry victim buffer. Every fourth block then lands on the same set, and a handful of requests is enough to drive one set through a chain of evictions. That chain fills the victim buffer, swaps blocks back and forth, and forces a dirty entry out through a write-back and a clean one out silently. Memory read and write counts are compared against the expected traffic, and response latency is measured from the accepting edge.

// File: rtl/dmvc_pkg.sv
`timescale 1ns/1ps
package dmvc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FETCH,
        ST_WAIT
    } dmvc_state_e;
endpackage

// File: rtl/dmvc_main_array.sv
`timescale 1ns/1ps
module dmvc_main_array #(
    parameter int SETS  = 256,
    parameter int IDX_W = 8,
    parameter int TAG_W = 4,
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag,
    output logic [BLK_W-1:0] line_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [BLK_W-1:0] wr_data
);
    typedef struct packed {
        logic [SETS-1:0] vld;
        logic [SETS-1:0] dty;
    } flags_t;

    flags_t st_q, st_d;
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [BLK_W-1:0] dat_mem [SETS];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_idx] = wr_valid;
            st_d.dty[wr_idx] = wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            dat_mem[wr_idx] <= wr_data;
        end
    end

    assign line_valid = st_q.vld[rd_idx];
    assign line_dirty = st_q.dty[rd_idx];
    assign line_tag   = tag_mem[rd_idx];
    assign line_data  = dat_mem[rd_idx];
    assign hit        = line_valid && (line_tag == rd_tag);

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld[rd_idx] |-> !st_q.dty[rd_idx]); // R3
endmodule

// File: rtl/dmvc_victim_buf.sv
`timescale 1ns/1ps
module dmvc_victim_buf #(
    parameter int N     = 4,
    parameter int BA_W  = 12,
    parameter int BLK_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BA_W-1:0]   lk_baddr,
    output logic              hit,
    output logic              hit_dirty,
    output logic [BLK_W-1:0]  hit_data,
    output logic              full,
    output logic              last_dirty,
    output logic [BA_W-1:0]   last_baddr,
    output logic [BLK_W-1:0]  last_data,
    input  logic              swap_en,
    input  logic              ins_en,
    input  logic              clean_last,
    input  logic              in_valid,
    input  logic              in_dirty,
    input  logic [BA_W-1:0]   in_baddr,
    input  logic [BLK_W-1:0]  in_data
);
    localparam int VIDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic             vld;
        logic             dty;
        logic [BA_W-1:0]  ba;
        logic [BLK_W-1:0] dat;
    } ent_t;

    ent_t [N-1:0]      ent_q, ent_d;
    logic [N-1:0]      match;
    logic [VIDX_W-1:0] match_idx;
    ent_t              new_ent;

    always_comb begin
        match_idx = '0;
        hit_dirty = 1'b0;
        hit_data  = '0;
        for (int i = 0; i < N; i++) begin
            match[i] = ent_q[i].vld && (ent_q[i].ba == lk_baddr);
            if (match[i]) begin
                match_idx = VIDX_W'(i);
                hit_dirty = ent_q[i].dty;
                hit_data  = ent_q[i].dat;
            end
        end
        hit = |match;
    end

    always_comb begin
        full = 1'b1;
        for (int i = 0; i < N; i++) full = full & ent_q[i].vld;
    end

    assign last_dirty = ent_q[N-1].vld && ent_q[N-1].dty;
    assign last_baddr = ent_q[N-1].ba;
    assign last_data  = ent_q[N-1].dat;

    always_comb begin
        int hole;
        new_ent = '{vld: in_valid, dty: in_dirty, ba: in_baddr, dat: in_data};
        ent_d   = ent_q;
        hole    = N - 1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_q[i].vld) hole = i;
        end
        if (swap_en) begin
            ent_d[match_idx] = new_ent;
        end else if (ins_en) begin
            for (int i = 1; i < N; i++) begin
                if (i <= hole) ent_d[i] = ent_q[i-1];
            end
            ent_d[0] = new_ent;
        end else if (clean_last) begin
            ent_d[N-1].dty = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    AST_VB_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R7
endmodule

// File: rtl/dmvc_cache.sv
`timescale 1ns/1ps
module dmvc_cache #(
    parameter int ADDR_W    = 14,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int SETS      = 256,
    parameter int VB_N      = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req_valid,
    output logic                        cpu_req_ready,
    input  logic                        cpu_req_write,
    input  logic [ADDR_W-1:0]           cpu_req_addr,
    input  logic [WORD_W-1:0]           cpu_req_wdata,
    output logic                        cpu_resp_valid,
    output logic [WORD_W-1:0]           cpu_resp_rdata,
    output logic                        mem_req_valid,
    input  logic                        mem_req_ready,
    output logic                        mem_req_write,
    output logic [ADDR_W-$clog2(BLK_WORDS)-1:0] mem_req_baddr,
    output logic [WORD_W*BLK_WORDS-1:0] mem_req_wdata,
    input  logic                        mem_resp_valid,
    input  logic [WORD_W*BLK_WORDS-1:0] mem_resp_rdata
);
    import dmvc_pkg::*;

    localparam int WSEL_W = $clog2(BLK_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int BA_W   = ADDR_W - WSEL_W;
    localparam int TAG_W  = BA_W - IDX_W;
    localparam int BLK_W  = WORD_W * BLK_WORDS;

    typedef struct packed {
        dmvc_state_e       st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [WSEL_W-1:0] req_wsel;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [BA_W-1:0]   req_baddr;

    logic              arr_hit, line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [BLK_W-1:0]  line_data;
    logic              arr_we, arr_wv, arr_wd;
    logic [TAG_W-1:0]  arr_wt;
    logic [BLK_W-1:0]  arr_wdat;

    logic              vb_hit, vb_hit_dirty, vb_full, vb_last_dirty;
    logic [BLK_W-1:0]  vb_hit_data, vb_last_data;
    logic [BA_W-1:0]   vb_last_baddr;
    logic              vb_swap, vb_ins, vb_clean;

    logic [WORD_W-1:0] hit_word;
    logic [BLK_W-1:0]  merged;

    assign req_wsel  = ctl_q.addr[WSEL_W-1:0];
    assign req_idx   = ctl_q.addr[WSEL_W +: IDX_W];
    assign req_tag   = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign req_baddr = ctl_q.addr[ADDR_W-1:WSEL_W];

    dmvc_main_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (req_idx),
        .rd_tag     (req_tag),
        .hit        (arr_hit),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .line_data  (line_data),
        .wr_en      (arr_we),
        .wr_idx     (req_idx),
        .wr_valid   (arr_wv),
        .wr_dirty   (arr_wd),
        .wr_tag     (arr_wt),
        .wr_data    (arr_wdat)
    );

    dmvc_victim_buf #(.N(VB_N), .BA_W(BA_W), .BLK_W(BLK_W)) u_vbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_baddr   (req_baddr),
        .hit        (vb_hit),
        .hit_dirty  (vb_hit_dirty),
        .hit_data   (vb_hit_data),
        .full       (vb_full),
        .last_dirty (vb_last_dirty),
        .last_baddr (vb_last_baddr),
        .last_data  (vb_last_data),
        .swap_en    (vb_swap),
        .ins_en     (vb_ins),
        .clean_last (vb_clean),
        .in_valid   (line_valid),
        .in_dirty   (line_dirty),
        .in_baddr   ({line_tag, req_idx}),
        .in_data    (line_data)
    );

    always_comb begin
        hit_word = '0;
        merged   = line_data;
        for (int w = 0; w < BLK_WORDS; w++) begin
            if (WSEL_W'(w) == req_wsel) begin
                hit_word = line_data[w*WORD_W +: WORD_W];
                merged[w*WORD_W +: WORD_W] = ctl_q.wdata;
            end
        end
    end

    always_comb begin
        ctl_d          = ctl_q;
        cpu_req_ready  = (ctl_q.st == ST_IDLE);
        cpu_resp_valid = 1'b0;
        cpu_resp_rdata = hit_word;
        mem_req_valid  = 1'b0;
        mem_req_write  = 1'b0;
        mem_req_baddr  = req_baddr;
        mem_req_wdata  = vb_last_data;
        arr_we         = 1'b0;
        arr_wv         = 1'b1;
        arr_wd         = 1'b0;
        arr_wt         = req_tag;
        arr_wdat       = merged;
        vb_swap        = 1'b0;
        vb_ins         = 1'b0;
        vb_clean       = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    ctl_d.st    = ST_LOOKUP;
                    ctl_d.wr    = cpu_req_write;
                    ctl_d.addr  = cpu_req_addr;
                    ctl_d.wdata = cpu_req_wdata;
                end
            end
            ST_LOOKUP: begin
                if (arr_hit) begin
                    cpu_resp_valid = 1'b1;
                    if (ctl_q.wr) begin
                        cpu_resp_rdata = ctl_q.wdata;
                        arr_we         = 1'b1;
                        arr_wd         = 1'b1;
                    end
                    ctl_d.st = ST_IDLE;
                end else if (vb_hit) begin
                    arr_we   = 1'b1;
                    arr_wd   = vb_hit_dirty;
                    arr_wdat = vb_hit_data;
                    vb_swap  = 1'b1;
                end else if (line_valid && vb_full && vb_last_dirty) begin
                    ctl_d.st = ST_WBACK;
                end else begin
                    if (line_valid) begin
                        vb_ins   = 1'b1;
                        arr_we   = 1'b1;
                        arr_wv   = 1'b0;
                        arr_wt   = line_tag;
                        arr_wdat = line_data;
                    end
                    ctl_d.st = ST_FETCH;
                end
            end
            ST_WBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_baddr = vb_last_baddr;
                if (mem_req_ready) begin
                    vb_clean = 1'b1;
                    ctl_d.st = ST_LOOKUP;
                end
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_resp_valid) begin
                    arr_we   = 1'b1;
                    arr_wdat = mem_resp_rdata;
                    ctl_d.st = ST_LOOKUP;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, wr: 1'b0, addr: '0, wdata: '0};
        else        ctl_q <= ctl_d;
    end

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> !mem_req_valid); // R2
    AST_FETCH_DOUBLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> (!arr_hit && !vb_hit)); // R9
    AST_SWAP_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LOOKUP && !arr_hit && vb_hit) |=> arr_hit); // R5
    AST_WB_DIRTY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (vb_full && vb_last_dirty)); // R8
    AST_EVICT_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_LOOKUP && !arr_hit && !vb_hit && line_valid && !(vb_full && vb_last_dirty))
        |=> (ctl_q.st == ST_FETCH && !line_valid)); // R4
endmodule

// File: tb/tb_dmvc_cache.sv
`timescale 1ns/1ps
module tb_dmvc_cache;
    localparam int AW = 8;
    localparam int NBLK = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic         cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [31:0]  cpu_req_wdata = '0;
    logic         cpu_req_ready, cpu_resp_valid;
    logic [31:0]  cpu_resp_rdata;
    logic         mem_req_valid, mem_req_write;
    logic         mem_req_ready = 1'b1;
    logic [5:0]   mem_req_baddr;
    logic [127:0] mem_req_wdata;
    logic         mem_resp_valid = 1'b0;
    logic [127:0] mem_resp_rdata = '0;

    dmvc_cache #(.ADDR_W(AW), .SETS(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
        .mem_req_baddr(mem_req_baddr), .mem_req_wdata(mem_req_wdata),
        .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [127:0] mem [NBLK];
    logic [31:0]  shadow [256];
    int rd_cnt = 0, wr_cnt = 0, pend = 0;
    logic [5:0] pend_a;

    logic [31:0] exp_q [$];
    int          lat_q [$];
    longint      t_q   [$];
    string       rq_q  [$];

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic int wa(input int t, input int i, input int w);
        return (t << 4) | (i << 2) | w;
    endfunction

    // memory model: fixed 3-cycle read latency, writes absorbed at once
    always @(negedge clk) begin
        mem_resp_valid = 1'b0;
        if (rst_n) begin
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_rdata = mem[pend_a];
                end
            end
            if (mem_req_valid) begin
                if (mem_req_write) begin
                    mem[mem_req_baddr] = mem_req_wdata;
                    wr_cnt++;
                end else if (pend == 0) begin
                    pend_a = mem_req_baddr;
                    pend = 3;
                    rd_cnt++;
                end
            end
        end
    end

    // monitor: pops expected responses
    always @(negedge clk) begin
        if (cpu_resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected response", cpu_resp_rdata, 0);
            end else begin
                logic [31:0] e;
                int l;
                longint t, lat;
                string r;
                e = exp_q.pop_front(); l = lat_q.pop_front();
                t = t_q.pop_front();   r = rq_q.pop_front();
                lat = ($time - t) / 4;
                chk(cpu_resp_rdata == e, {r, " data"}, cpu_resp_rdata, e);
                if (l != 0) chk(lat == l, {r, " latency"}, lat, l);
            end
        end
    end

    task automatic cpu_op(input bit wr, input int addr, input logic [31:0] wd,
                          input int lat, input string rq);
        logic [31:0] e;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr;
        cpu_req_addr = AW'(addr); cpu_req_wdata = wd;
        while (!cpu_req_ready) @(negedge clk);
        if (wr) shadow[addr] = wd;
        e = shadow[addr];
        exp_q.push_back(e); lat_q.push_back(lat);
        t_q.push_back($time); rq_q.push_back(rq);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        wait (exp_q.size() == 0);
    endtask

    task automatic traffic(input int rd_exp, input int wr_exp, input string rq);
        chk(rd_cnt == rd_exp, {rq, " mem reads"}, rd_cnt, rd_exp);
        chk(wr_cnt == wr_exp, {rq, " mem writes"}, wr_cnt, wr_exp);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            summary();
            $finish;
        end
    end

    localparam logic [31:0] XW = 32'hDEAD_0042;

    initial begin
        for (int b = 0; b < NBLK; b++)
            for (int w = 0; w < 4; w++) begin
                mem[b][w*32 +: 32] = 32'hA000_0000 | (b << 8) | w;
                shadow[b*4 + w]    = 32'hA000_0000 | (b << 8) | w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cpu_req_ready == 1'b1, "R1 ready", cpu_req_ready, 1);
        chk(cpu_resp_valid == 1'b0, "R1 resp_valid", cpu_resp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);

        cpu_op(0, wa(0,0,1), 0, 0, "R1 cold miss R9 word1");
        traffic(1, 0, "R1");
        cpu_op(0, wa(0,0,3), 0, 1, "R2 hit word3");
        traffic(1, 0, "R2");
        cpu_op(1, wa(0,0,2), XW, 1, "R3 write hit");
        traffic(1, 0, "R3");
        cpu_op(0, wa(0,0,2), 0, 1, "R3 read back");
        cpu_op(0, wa(0,1,0), 0, 0, "R9 other set miss");
        cpu_op(0, wa(0,1,0), 0, 1, "R2 other set hit");
        traffic(2, 0, "R9");
        // conflict: dirty T0 moves to victim buffer
        cpu_op(0, wa(1,0,0), 0, 0, "R4 conflict miss");
        traffic(3, 0, "R4");
        cpu_op(0, wa(0,0,2), 0, 2, "R5 R6 victim hit dirty");
        cpu_op(0, wa(1,0,1), 0, 2, "R5 swap back");
        traffic(3, 0, "R5");
        cpu_op(0, wa(2,0,0), 0, 0, "R7 fill a");
        cpu_op(0, wa(3,0,0), 0, 0, "R7 fill b");
        cpu_op(0, wa(4,0,0), 0, 0, "R7 fill c");
        traffic(6, 0, "R7 buffer full");
        // buffer full, oldest (dirty T0) must be written back
        cpu_op(0, wa(5,0,3), 0, 0, "R8 push dirty");
        traffic(7, 1, "R8");
        chk(mem[0][2*32 +: 32] == XW, "R8 R6 written-back word", mem[0][2*32 +: 32], XW);
        chk(mem[0][1*32 +: 32] == 32'hA000_0001, "R8 untouched word", mem[0][1*32 +: 32], 32'hA000_0001);
        cpu_op(0, wa(1,0,2), 0, 2, "R7 newer entry kept");
        traffic(7, 1, "R7");
        // oldest now clean T5: dropped silently
        cpu_op(0, wa(0,0,2), 0, 0, "R6 refetch written data");
        traffic(8, 1, "R8 clean drop");
        cpu_op(0, wa(5,0,0), 0, 0, "R7 oldest was dropped");
        traffic(9, 1, "R7 drop");
        cpu_op(0, wa(3,0,1), 0, 2, "R7 order kept");
        traffic(9, 1, "R5 R9 victim no fetch");
        cpu_op(1, wa(6,2,1), 32'h1234_5678, 0, "R3 write miss allocate");
        cpu_op(0, wa(6,2,1), 0, 1, "R3 allocated word");
        cpu_op(0, wa(6,2,0), 0, 1, "R9 neighbour word");
        traffic(10, 1, "R3 alloc");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule